// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Load Cache

This block is the load lookup stage of a small two-way cache that sits between a CPU load port and the next memory level. The set is chosen only from address bits that translation leaves unchanged (the bits inside the page offset). The stored tags and valid bits of the selected set can therefore be read while the translator is still busy with the upper address bits. Once the translator returns a physical page number, the stored physical tags are compared with it to decide hit or miss.

On a hit, the requested 32-bit word is returned. On a miss, one line request goes to the next level. The refill words are written into the chosen way, and only when the whole line is in place is the load answered. Only one load is outstanding at a time. Since the placement depends only on physical-address bits, two virtual pages mapped to one physical page share a single cache line and never produce two copies.

Top module: `vipt_cache`

## Requirements
- R1: The set number is address bits [OFF_W+SET_W-1:OFF_W] of the load address (bits [9:6] by default), which must lie inside the PAGE_W page-offset bits. A line request carries these same bits at the same position, and its low OFF_W bits are zero.
- R2: While a load waits for translation, `xlat_req_valid` is high and `xlat_vpn` equals load address bits [VA_W-1:PAGE_W].
- R3: A translation that is absent, or reported with `xlat_hit` low, leaves the load waiting: `xlat_req_valid` stays high, and neither a response nor a memory request appears.
- R4: The physical tag is physical address bits [PA_W-1:OFF_W+SET_W], where the physical address is {ppn, page offset}. A tag match on a valid way in the cycle `xlat_valid` and `xlat_hit` are high raises `resp_valid` for exactly one cycle after that edge, with the addressed word and no memory request.
- R5: On a tag miss, `mem_req_valid` rises the cycle after the deciding edge, with `mem_req_addr` = physical line address. It holds steady until a cycle with `mem_req_ready` high.
- R6: After the request is accepted, a refill is 2^(OFF_W-2) words in ascending word order, each marked by `mem_rvalid`, with gaps allowed. The response comes one cycle after the last word, with the word selected by load address bits [OFF_W-1:2].
- R7: Two virtual addresses with equal page offset and equal physical page number hit the same line.
- R8: The victim is way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the least recently used way of the set. Both a hit and a fill make the used way most recent.
- R9: After reset, no way is valid, `req_ready` is 1, and `resp_valid`, `mem_req_valid` and `xlat_req_valid` are 0.
- R10: `req_ready` is high only when no load is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Load request |
| req_vaddr | input | VA_W | Virtual byte address of the load |
| req_ready | output | 1 | Ready to accept a load |
| xlat_req_valid | output | 1 | Translation wanted |
| xlat_vpn | output | VA_W-PAGE_W | Virtual page number to translate |
| xlat_valid | input | 1 | Translator response present |
| xlat_hit | input | 1 | Translation found |
| xlat_ppn | input | PA_W-PAGE_W | Physical page number |
| mem_req_valid | output | 1 | Line request to next level |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_addr | output | PA_W | Physical line address |
| mem_rvalid | input | 1 | Refill word present |
| mem_rdata | input | WORD_W | Refill word |
| resp_valid | output | 1 | Load answered |
| resp_data | output | WORD_W | Loaded word |

## Verification
A hit must answer exactly one clock after the edge that first sees a valid, successful translation. A miss must raise its line request one clock after that same edge and keep it until the handshake edge. The miss response must arrive one clock after the edge that takes the last refill word. The bench drives all inputs 2 ns after a rising edge and has a behavioural model predict, for every falling edge, the levels of `resp_valid`, `mem_req_valid` and `xlat_req_valid` and the response word. Stalls are placed in the translation and refill phases so that an answer arriving early or late shows up as a mismatch on that falling edge.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_MREQ = 2'd2,
        ST_FILL = 2'd3
    } lookup_state_e;
endpackage

// File: rtl/vipt_way.sv
module vipt_way #(
    parameter int SET_W  = 4,
    parameter int TAG_W  = 22,
    parameter int WSEL_W = 4,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    input  logic              dwe,
    input  logic [SET_W-1:0]  wset,
    input  logic [WSEL_W-1:0] wword,
    input  logic [WORD_W-1:0] wdata,
    input  logic              twe,
    input  logic [TAG_W-1:0]  wtag
);
    localparam int SETS  = 1 << SET_W;
    localparam int WORDS = SETS << WSEL_W;

    logic [TAG_W-1:0]  tag_mem [SETS];
    logic [WORD_W-1:0] dat_mem [WORDS];
    logic [SETS-1:0]   vld_q;

    assign rd_tag   = tag_mem[rd_set];
    assign rd_valid = vld_q[rd_set];
    assign rd_data  = dat_mem[{rd_set, rd_word}];

    always_ff @(posedge clk) begin
        if (dwe) dat_mem[{wset, wword}] <= wdata;
        if (twe) tag_mem[wset] <= wtag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   vld_q <= '0;
        else if (twe) vld_q[wset] <= 1'b1;
    end
endmodule

// File: rtl/vipt_lru.sv
module vipt_lru #(
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic             rd_lru,
    input  logic             upd,
    input  logic [SET_W-1:0] upd_set,
    input  logic             upd_mru
);
    localparam int SETS = 1 << SET_W;
    logic [SETS-1:0] lru_q;

    assign rd_lru = lru_q[rd_set];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   lru_q <= '0;
        else if (upd) lru_q[upd_set] <= ~upd_mru;
    end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int PAGE_W = 13,
    parameter int OFF_W  = 6,
    parameter int SET_W  = 4,
    parameter int WORD_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        req_vaddr,
    output logic                   req_ready,
    output logic                   xlat_req_valid,
    output logic [VA_W-PAGE_W-1:0] xlat_vpn,
    input  logic                   xlat_valid,
    input  logic                   xlat_hit,
    input  logic [PA_W-PAGE_W-1:0] xlat_ppn,
    output logic                   mem_req_valid,
    input  logic                   mem_req_ready,
    output logic [PA_W-1:0]        mem_req_addr,
    input  logic                   mem_rvalid,
    input  logic [WORD_W-1:0]      mem_rdata,
    output logic                   resp_valid,
    output logic [WORD_W-1:0]      resp_data
);
    import vipt_pkg::*;

    localparam int WAYS    = 2;
    localparam int IDX_HI  = OFF_W + SET_W;
    localparam int TAG_W   = PA_W - IDX_HI;
    localparam int BYTE_SH = $clog2(WORD_W / 8);
    localparam int WSEL_W  = OFF_W - BYTE_SH;
    localparam int BEATS   = 1 << WSEL_W;

    typedef struct packed {
        lookup_state_e     state;
        logic [VA_W-1:0]   vaddr;
        logic [TAG_W-1:0]  ptag;
        logic              victim;
        logic [WSEL_W-1:0] beat;
        logic [WORD_W-1:0] hold;
        logic              resp_v;
        logic [WORD_W-1:0] resp_data;
    } lookup_st_t;

    lookup_st_t st_d, st_q;

    logic [SET_W-1:0]  set_idx;
    logic [WSEL_W-1:0] word_idx;
    logic [PA_W-1:0]   paddr_now;
    logic [TAG_W-1:0]  ptag_now;
    logic [TAG_W-1:0]  way_tag   [WAYS];
    logic [WORD_W-1:0] way_data  [WAYS];
    logic [WAYS-1:0]   way_valid;
    logic [WAYS-1:0]   way_hit;
    logic              set_lru;
    logic              victim_now;
    logic              fill_we, tag_we, lru_upd, lru_mru;

    assign set_idx   = st_q.vaddr[IDX_HI-1:OFF_W];
    assign word_idx  = st_q.vaddr[OFF_W-1:BYTE_SH];
    assign paddr_now = {xlat_ppn, st_q.vaddr[PAGE_W-1:0]};
    assign ptag_now  = paddr_now[PA_W-1:IDX_HI];

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        vipt_way #(
            .SET_W(SET_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W), .WORD_W(WORD_W)
        ) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_set   (set_idx),
            .rd_word  (word_idx),
            .rd_tag   (way_tag[g]),
            .rd_valid (way_valid[g]),
            .rd_data  (way_data[g]),
            .dwe      (fill_we && (st_q.victim == 1'(g))),
            .wset     (set_idx),
            .wword    (st_q.beat),
            .wdata    (mem_rdata),
            .twe      (tag_we && (st_q.victim == 1'(g))),
            .wtag     (st_q.ptag)
        );
        assign way_hit[g] = way_valid[g] && (way_tag[g] == ptag_now);
    end

    vipt_lru #(.SET_W(SET_W)) u_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (set_idx),
        .rd_lru  (set_lru),
        .upd     (lru_upd),
        .upd_set (set_idx),
        .upd_mru (lru_mru)
    );

    assign victim_now = !way_valid[0] ? 1'b0 :
                        !way_valid[1] ? 1'b1 : set_lru;

    always_comb begin
        st_d        = st_q;
        st_d.resp_v = 1'b0;
        fill_we     = 1'b0;
        tag_we      = 1'b0;
        lru_upd     = 1'b0;
        lru_mru     = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.vaddr = req_vaddr;
                    st_d.state = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (xlat_valid && xlat_hit) begin
                    if (|way_hit) begin
                        st_d.resp_v    = 1'b1;
                        st_d.resp_data = way_hit[1] ? way_data[1] : way_data[0];
                        lru_upd        = 1'b1;
                        lru_mru        = way_hit[1];
                        st_d.state     = ST_IDLE;
                    end else begin
                        st_d.ptag   = ptag_now;
                        st_d.victim = victim_now;
                        st_d.beat   = '0;
                        st_d.state  = ST_MREQ;
                    end
                end
            end
            ST_MREQ: begin
                if (mem_req_ready) st_d.state = ST_FILL;
            end
            ST_FILL: begin
                if (mem_rvalid) begin
                    fill_we   = 1'b1;
                    st_d.beat = st_q.beat + 1'b1;
                    if (st_q.beat == word_idx) st_d.hold = mem_rdata;
                    if (st_q.beat == WSEL_W'(BEATS - 1)) begin
                        tag_we         = 1'b1;
                        lru_upd        = 1'b1;
                        lru_mru        = st_q.victim;
                        st_d.resp_v    = 1'b1;
                        st_d.resp_data = (st_q.beat == word_idx) ? mem_rdata : st_q.hold;
                        st_d.state     = ST_IDLE;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready      = (st_q.state == ST_IDLE);
    assign xlat_req_valid = (st_q.state == ST_LOOK);
    assign xlat_vpn       = st_q.vaddr[VA_W-1:PAGE_W];
    assign mem_req_valid  = (st_q.state == ST_MREQ);
    assign mem_req_addr   = {st_q.ptag, set_idx, {OFF_W{1'b0}}};
    assign resp_valid     = st_q.resp_v;
    assign resp_data      = st_q.resp_data;
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int PAGE_W = 13,
    parameter int OFF_W  = 6,
    parameter int SET_W  = 4,
    parameter int WORD_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [VA_W-1:0]        req_vaddr,
    input logic                   req_ready,
    input logic                   xlat_req_valid,
    input logic [VA_W-PAGE_W-1:0] xlat_vpn,
    input logic                   xlat_valid,
    input logic                   xlat_hit,
    input logic                   mem_req_valid,
    input logic                   mem_req_ready,
    input logic [PA_W-1:0]        mem_req_addr,
    input logic                   mem_rvalid,
    input logic                   resp_valid
);
    localparam int IDX_HI = OFF_W + SET_W;

    logic [VA_W-1:0] acc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      acc_q <= '0;
        else if (req_valid && req_ready) acc_q <= req_vaddr;
    end

    assert_set_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[IDX_HI-1:OFF_W] == acc_q[IDX_HI-1:OFF_W])
                          && (mem_req_addr[OFF_W-1:0] == '0));

    assert_vpn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req_valid |-> xlat_vpn == acc_q[VA_W-1:PAGE_W]);

    assert_xlat_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req_valid && !(xlat_valid && xlat_hit)) |=>
            (xlat_req_valid && !resp_valid && !mem_req_valid));

    assert_resp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_mreq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_resp_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) |-> ($past(mem_rvalid) || $past(xlat_valid && xlat_hit && xlat_req_valid)));

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!xlat_req_valid && !mem_req_valid));
endmodule

bind vipt_cache vipt_cache_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W),
    .OFF_W(OFF_W), .SET_W(SET_W), .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/tb_vipt_cache.sv
module tb_vipt_cache;
    localparam int VA_W = 32, PA_W = 32, PAGE_W = 13, OFF_W = 6, SET_W = 4, WORD_W = 32;
    localparam int PPN_W = PA_W - PAGE_W;
    localparam int SETS = 16, BEATS = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic req_ready, xlat_req_valid, mem_req_valid, resp_valid;
    logic [VA_W-PAGE_W-1:0] xlat_vpn;
    logic xlat_valid = 1'b0, xlat_hit = 1'b0;
    logic [PPN_W-1:0] xlat_ppn = '0;
    logic mem_req_ready = 1'b0, mem_rvalid = 1'b0;
    logic [PA_W-1:0] mem_req_addr;
    logic [WORD_W-1:0] mem_rdata = '0, resp_data;

    vipt_cache dut (.*);

    int checks = 0, errors = 0;
    bit done = 0;
    bit exp_resp = 0, exp_mreq = 0, exp_xreq = 0;
    logic [31:0] exp_data = '0;
    string cur_req = "R9";

    bit          mv [SETS][2];
    logic [21:0] mt [SETS][2];
    bit          ml [SETS];

    function automatic logic [31:0] mem_word(input logic [31:0] pa);
        return ((pa >> 2) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(resp_valid == exp_resp, {cur_req, " R4 R6 resp_valid"}, 32'(resp_valid), 32'(exp_resp));
            if (exp_resp && resp_valid)
                chk(resp_data == exp_data, {cur_req, " R4 R6 resp_data"}, resp_data, exp_data);
            chk(mem_req_valid == exp_mreq, {cur_req, " R5 mem_req_valid"}, 32'(mem_req_valid), 32'(exp_mreq));
            chk(xlat_req_valid == exp_xreq, {cur_req, " R3 xlat_req_valid"}, 32'(xlat_req_valid), 32'(exp_xreq));
        end
    end

    task automatic load(input logic [31:0] va, input logic [PPN_W-1:0] ppn,
                        input int xdelay, input int xmiss, input string tag);
        logic [31:0] pa, line;
        logic [21:0] ptag;
        int set, way;
        bit hit;
        cur_req = tag;
        pa   = {ppn, va[PAGE_W-1:0]};
        line = {pa[31:6], 6'b0};
        ptag = pa[31:10];
        set  = int'(va[9:6]);
        hit  = 0; way = 0;
        for (int w = 0; w < 2; w++)
            if (mv[set][w] && mt[set][w] == ptag) begin hit = 1; way = w; end
        @(posedge clk); #2;
        req_valid = 1'b1; req_vaddr = va;
        @(posedge clk); #2;
        req_valid = 1'b0; exp_xreq = 1'b1;
        chk(xlat_vpn == va[31:13], {tag, " R2 vpn"}, 32'(xlat_vpn), 32'(va[31:13]));
        chk(req_ready == 1'b0, {tag, " R10 ready busy"}, 32'(req_ready), 0);
        for (int i = 0; i <= xdelay + xmiss; i++) begin
            xlat_valid = (i >= xdelay);
            xlat_hit   = (i == xdelay + xmiss);
            xlat_ppn   = (i == xdelay + xmiss) ? ppn : ~ppn;
            @(posedge clk); #2;
        end
        xlat_valid = 1'b0; xlat_hit = 1'b0; exp_xreq = 1'b0;
        if (hit) begin
            ml[set] = (way == 0);
            exp_resp = 1'b1; exp_data = mem_word(pa);
            @(posedge clk); #2;
            exp_resp = 1'b0;
        end else begin
            way = !mv[set][0] ? 0 : (!mv[set][1] ? 1 : int'(ml[set]));
            exp_mreq = 1'b1;
            chk(mem_req_addr == line, {tag, " R1 R5 R8 line addr"}, mem_req_addr, line);
            mem_req_ready = 1'b0;
            @(posedge clk); #2;
            chk(mem_req_addr == line, {tag, " R5 addr held"}, mem_req_addr, line);
            mem_req_ready = 1'b1;
            @(posedge clk); #2;
            mem_req_ready = 1'b0; exp_mreq = 1'b0;
            for (int b = 0; b < BEATS; b++) begin
                if (b == 5) begin
                    mem_rvalid = 1'b0;
                    @(posedge clk); #2;
                end
                mem_rvalid = 1'b1;
                mem_rdata  = mem_word(line + 32'(b * 4));
                @(posedge clk); #2;
            end
            mem_rvalid = 1'b0;
            mv[set][way] = 1; mt[set][way] = ptag; ml[set] = (way == 0);
            exp_resp = 1'b1; exp_data = mem_word(pa);
            @(posedge clk); #2;
            exp_resp = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_sim();
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            mv[s][0] = 0; mv[s][1] = 0; ml[s] = 0; mt[s][0] = '0; mt[s][1] = '0;
        end
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready in reset", 32'(req_ready), 1);
        chk(resp_valid == 1'b0, "R9 resp in reset", 32'(resp_valid), 0);
        chk(mem_req_valid == 1'b0, "R9 mreq in reset", 32'(mem_req_valid), 0);
        chk(xlat_req_valid == 1'b0, "R9 xreq in reset", 32'(xlat_req_valid), 0);
        @(posedge clk); #2 rst_n = 1'b1;

        load(32'h0000_1048, 19'h00123, 1, 0, "R5 R6 first miss");
        load(32'h0000_1048, 19'h00123, 2, 2, "R3 R4 stalled hit");
        load(32'h4000_3048, 19'h00123, 0, 0, "R7 alias hit");
        load(32'h7777_707C, 19'h00123, 0, 1, "R7 alias last word");
        load(32'h0000_1040, 19'h00456, 0, 0, "R8 fill way1");
        load(32'h0000_1040, 19'h00123, 1, 0, "R8 touch way0");
        load(32'h0000_1044, 19'h00789, 0, 0, "R8 evict lru");
        load(32'h0000_1050, 19'h00456, 0, 0, "R8 refetch");
        load(32'h0000_1048, 19'h00123, 0, 0, "R8 refetch old");
        load(32'h0000_0048, 19'h00123, 0, 0, "R4 offset bit above index");
        load(32'h0000_0000, 19'h00ABC, 0, 0, "R6 first word");
        load(32'h0000_003C, 19'h00ABC, 3, 0, "R4 last word hit");

        repeat (2) @(posedge clk);
        done = 1;
        finish_sim();
    end
endmodule